// File: doc/BRIEF.md
# Per-Line Snooping Coherence Controller

This block runs the coherence state machine for one line of a private cache attached to a totally ordered snooping bus. A request leaves the cache some cycles before the bus orders it, so the line can pass through transient states in the meantime. The controller keeps the line in one of four stable states: invalid, shared, exclusive-clean or modified. It turns core loads, stores and replacements into bus requests. It also reacts to the requests it snoops, including its own requests once the bus has ordered them.

The snoop port carries each ordered bus request together with a flag that marks this controller's own requests. A wired-OR shared line tells a reader whether any other cache holds the block. A read that finds no other holder installs the line exclusive-clean, so a later store needs no bus traffic. The transient states cover the races between a request being issued and that request appearing on the bus. Examples are an upgrade that loses to another writer, and a writeback that loses to another core's write miss. Stable state uses a 3-bit field. The transient state sits in a separate miss-tracking register.

Top module: `snoop_line_ctrl`

## Requirements
- R1: After reset the line is invalid with no transaction open: coreReady is 1, and busReqValid, coreDone, dataSendValid and sharedOut are 0.
- R2: A load (coreOp 0) to an invalid line drives busReqValid with busReqType 0 (GetS). It does so from the cycle after acceptance through the cycle in which the own GetS is snooped. The data response then pulses coreDone. The line becomes exclusive if sharedIn was 0 during the own-GetS snoop, and shared if it was 1.
- R3: A store (coreOp 1) to an invalid line requests GetM (busReqType 1) and waits for its own GetM, ignoring earlier foreign requests. The data response that follows completes the store, and the line becomes modified. busReqType does not change while a request is outstanding.
- R4: A store to a shared line requests GetM. If a foreign GetM is snooped before the own GetM, the line is invalidated and the request carries on as a miss from invalid. Either path ends with coreDone after the data response.
- R5: On an exclusive line, a store completes with no bus request and makes the line modified. A foreign GetS makes the line shared with no data sent. A replacement (coreOp 2) completes with no bus request and makes the line invalid.
- R6: A modified line responds to snooped foreign requests with a dataSendValid pulse. A foreign GetS gives dataSendMem 1 (the copy also goes to memory) and leaves the line shared. A foreign GetM gives dataSendMem 0 and leaves the line invalid.
- R7: Replacing a modified line requests PutM (busReqType 2). When the own PutM is snooped, the controller pulses dataSendValid with dataSendMem 1, pulses coreDone, and leaves the line invalid.
- R8: While that PutM is pending, a foreign GetM makes the controller send data to the requester (dataSendMem 0) and give up the line, but it keeps requesting PutM. The later own PutM completes the replacement with no data sent.
- R9: coreReady is 0 while any transaction is open and in any cycle with snoopValid high. A core request that meets a snoop in the same cycle is therefore taken afterwards, against the state the snoop left behind.
- R10: sharedOut is 1 in the cycle a foreign GetS is snooped while the line is held shared, exclusive or modified, and 0 otherwise.
- R11: A foreign GetS or GetM snooped after the own GetM but before the data is recorded. When the data arrives, the store completes and the data is forwarded in the same pulse. A GetM sends with dataSendMem 0 and leaves the line invalid. A GetS sends with dataSendMem 1 and leaves the line shared.
- R12: coreDone and dataSendValid are single-cycle pulses in the cycle after their cause. That cause is an accepted core request, an own snoop or a data response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreValid | input | 1 | Core request present |
| coreOp | input | 2 | 0 load, 1 store, 2 replace |
| coreReady | output | 1 | Core request can be taken this cycle |
| coreDone | output | 1 | Core request completed (pulse) |
| snoopValid | input | 1 | An ordered bus request is visible |
| snoopType | input | 2 | 0 GetS, 1 GetM, 2 PutM |
| snoopOwn | input | 1 | Snooped request came from this controller |
| sharedIn | input | 1 | Wired-OR shared line during own GetS |
| sharedOut | output | 1 | Drive the shared line for a foreign GetS |
| dataRespValid | input | 1 | Line data arrived for the open miss |
| busReqValid | output | 1 | Request waiting for the bus |
| busReqType | output | 2 | 0 GetS, 1 GetM, 2 PutM |
| dataSendValid | output | 1 | Send the line's data (pulse) |
| dataSendMem | output | 1 | Data also (or only) goes to memory |

## Verification
A core store can arrive in the same cycle that the controller snoops a foreign GetS on an exclusive line. The bench provokes this by holding a store on the core port during that snoop cycle. The cycle must show the stall and the shared-line answer. The held store is then accepted one cycle later, and it must raise a GetM instead of completing silently, because the snoop has already made the line shared. A second overlap sets a foreign GetM or GetS against a miss that has already been ordered but has no data yet. There the check is that the completion and the forward appear in the same pulse, with the right memory flag.

// File: rtl/snoop_line_pkg.sv
package snoop_line_pkg;

  localparam int STATE_W = 3;
  localparam int TRANS_W = 3;
  localparam int OP_W    = 2;
  localparam int BUS_W   = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_M = 3'd3
  } stable_e;

  typedef enum logic [TRANS_W-1:0] {
    TR_NONE  = 3'd0,
    TR_IS_AD = 3'd1,
    TR_IS_D  = 3'd2,
    TR_IM_AD = 3'd3,
    TR_IM_D  = 3'd4,
    TR_SM_AD = 3'd5,
    TR_MI_A  = 3'd6,
    TR_II_A  = 3'd7
  } trans_e;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_REPL  = 2'd2
  } coreop_e;

  typedef enum logic [BUS_W-1:0] {
    BUS_GETS = 2'd0,
    BUS_GETM = 2'd1,
    BUS_PUTM = 2'd2
  } busop_e;

  // Foreign request recorded while a miss waits for data.
  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_TO_S = 2'd1,
    PEND_TO_I = 2'd2
  } pend_e;

  typedef struct packed {
    logic    loadStable;
    stable_e nextStable;
    logic    loadTrans;
    trans_e  nextTrans;
    logic    captureShared;
    logic    loadPend;
    pend_e   nextPend;
    logic    done;
    logic    send;
    logic    sendMem;
  } strobes_t;

endpackage

// File: rtl/snoop_line_dp.sv
module snoop_line_dp
  import snoop_line_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            ctl,
  input  logic                sharedIn,
  input  logic                snoopValid,
  input  logic                snoopOwn,
  input  logic [BUS_W-1:0]    snoopType,
  output stable_e             stableQ,
  output trans_e              transQ,
  output logic                sharedQ,
  output pend_e               pendQ,
  output logic                busReqValid,
  output logic [BUS_W-1:0]    busReqType,
  output logic                coreReady,
  output logic                sharedOut,
  output logic                coreDone,
  output logic                dataSendValid,
  output logic                dataSendMem
);

  logic doneQ, sendQ, sendMemQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stableQ  <= ST_I;
      transQ   <= TR_NONE;
      sharedQ  <= 1'b0;
      pendQ    <= PEND_NONE;
      doneQ    <= 1'b0;
      sendQ    <= 1'b0;
      sendMemQ <= 1'b0;
    end else begin
      if (ctl.loadStable)    stableQ <= ctl.nextStable;
      if (ctl.loadTrans)     transQ  <= ctl.nextTrans;
      if (ctl.captureShared) sharedQ <= sharedIn;
      if (ctl.loadPend)      pendQ   <= ctl.nextPend;
      doneQ    <= ctl.done;
      sendQ    <= ctl.send;
      sendMemQ <= ctl.sendMem;
    end
  end

  // Request waiting for the bus, derived from the miss-tracking register.
  always_comb begin
    busReqValid = 1'b0;
    busReqType  = BUS_GETS;
    case (transQ)
      TR_IS_AD: begin
        busReqValid = 1'b1;
        busReqType  = BUS_GETS;
      end
      TR_IM_AD, TR_SM_AD: begin
        busReqValid = 1'b1;
        busReqType  = BUS_GETM;
      end
      TR_MI_A, TR_II_A: begin
        busReqValid = 1'b1;
        busReqType  = BUS_PUTM;
      end
      default: begin
        busReqValid = 1'b0;
        busReqType  = BUS_GETS;
      end
    endcase
  end

  assign coreReady     = (transQ == TR_NONE) && !snoopValid;
  assign sharedOut     = snoopValid && !snoopOwn && (snoopType == BUS_GETS)
                         && (stableQ != ST_I);
  assign coreDone      = doneQ;
  assign dataSendValid = sendQ;
  assign dataSendMem   = sendMemQ;

endmodule

// File: rtl/snoop_line_fsm.sv
module snoop_line_fsm
  import snoop_line_pkg::*;
(
  input  stable_e          stableQ,
  input  trans_e           transQ,
  input  logic             sharedQ,
  input  pend_e            pendQ,
  input  logic             coreValid,
  input  logic [OP_W-1:0]  coreOp,
  input  logic             coreReady,
  input  logic             snoopValid,
  input  logic [BUS_W-1:0] snoopType,
  input  logic             snoopOwn,
  input  logic             dataRespValid,
  output strobes_t         ctl
);

  logic otherGetS, otherGetM, ownGetS, ownGetM, ownPutM, accept;

  assign otherGetS = snoopValid && !snoopOwn && (snoopType == BUS_GETS);
  assign otherGetM = snoopValid && !snoopOwn && (snoopType == BUS_GETM);
  assign ownGetS   = snoopValid &&  snoopOwn && (snoopType == BUS_GETS);
  assign ownGetM   = snoopValid &&  snoopOwn && (snoopType == BUS_GETM);
  assign ownPutM   = snoopValid &&  snoopOwn && (snoopType == BUS_PUTM);
  assign accept    = coreValid && coreReady;

  always_comb begin
    ctl = '0;
    ctl.nextStable = ST_I;
    ctl.nextTrans  = TR_NONE;
    ctl.nextPend   = PEND_NONE;

    case (transQ)
      TR_NONE: begin
        if (snoopValid && !snoopOwn) begin
          // Foreign request against a stable line.
          case (stableQ)
            ST_E: begin
              if (otherGetS) begin
                ctl.loadStable = 1'b1; ctl.nextStable = ST_S;
              end else if (otherGetM) begin
                ctl.loadStable = 1'b1; ctl.nextStable = ST_I;
              end
            end
            ST_S: begin
              if (otherGetM) begin
                ctl.loadStable = 1'b1; ctl.nextStable = ST_I;
              end
            end
            ST_M: begin
              if (otherGetS) begin
                ctl.loadStable = 1'b1; ctl.nextStable = ST_S;
                ctl.send = 1'b1; ctl.sendMem = 1'b1;
              end else if (otherGetM) begin
                ctl.loadStable = 1'b1; ctl.nextStable = ST_I;
                ctl.send = 1'b1; ctl.sendMem = 1'b0;
              end
            end
            default: ;
          endcase
        end else if (accept) begin
          case (coreop_e'(coreOp))
            OP_LOAD: begin
              if (stableQ == ST_I) begin
                ctl.loadTrans = 1'b1; ctl.nextTrans = TR_IS_AD;
              end else begin
                ctl.done = 1'b1;
              end
            end
            OP_STORE: begin
              case (stableQ)
                ST_I: begin
                  ctl.loadTrans = 1'b1; ctl.nextTrans = TR_IM_AD;
                end
                ST_S: begin
                  ctl.loadTrans = 1'b1; ctl.nextTrans = TR_SM_AD;
                end
                ST_E: begin
                  ctl.loadStable = 1'b1; ctl.nextStable = ST_M;
                  ctl.done = 1'b1;
                end
                default: ctl.done = 1'b1;
              endcase
            end
            OP_REPL: begin
              case (stableQ)
                ST_M: begin
                  ctl.loadTrans = 1'b1; ctl.nextTrans = TR_MI_A;
                end
                ST_S, ST_E: begin
                  ctl.loadStable = 1'b1; ctl.nextStable = ST_I;
                  ctl.done = 1'b1;
                end
                default: ctl.done = 1'b1;
              endcase
            end
            default: ;
          endcase
        end
      end

      TR_IS_AD: begin
        if (ownGetS) begin
          ctl.loadTrans = 1'b1; ctl.nextTrans = TR_IS_D;
          ctl.captureShared = 1'b1;
          ctl.loadPend = 1'b1; ctl.nextPend = PEND_NONE;
        end
      end

      TR_IS_D: begin
        if (dataRespValid) begin
          ctl.loadTrans = 1'b1; ctl.nextTrans = TR_NONE;
          ctl.loadStable = 1'b1;
          if (pendQ == PEND_TO_I)                    ctl.nextStable = ST_I;
          else if (sharedQ || pendQ == PEND_TO_S)    ctl.nextStable = ST_S;
          else                                       ctl.nextStable = ST_E;
          ctl.loadPend = 1'b1; ctl.nextPend = PEND_NONE;
          ctl.done = 1'b1;
        end else if (otherGetM) begin
          ctl.loadPend = 1'b1; ctl.nextPend = PEND_TO_I;
        end else if (otherGetS && pendQ == PEND_NONE) begin
          ctl.loadPend = 1'b1; ctl.nextPend = PEND_TO_S;
        end
      end

      TR_IM_AD: begin
        if (ownGetM) begin
          ctl.loadTrans = 1'b1; ctl.nextTrans = TR_IM_D;
          ctl.loadPend = 1'b1; ctl.nextPend = PEND_NONE;
        end
      end

      TR_IM_D: begin
        if (dataRespValid) begin
          ctl.loadTrans = 1'b1; ctl.nextTrans = TR_NONE;
          ctl.loadStable = 1'b1;
          ctl.done = 1'b1;
          ctl.loadPend = 1'b1; ctl.nextPend = PEND_NONE;
          case (pendQ)
            PEND_TO_I: begin
              ctl.nextStable = ST_I; ctl.send = 1'b1; ctl.sendMem = 1'b0;
            end
            PEND_TO_S: begin
              ctl.nextStable = ST_S; ctl.send = 1'b1; ctl.sendMem = 1'b1;
            end
            default: ctl.nextStable = ST_M;
          endcase
        end else if (otherGetM) begin
          ctl.loadPend = 1'b1; ctl.nextPend = PEND_TO_I;
        end else if (otherGetS && pendQ == PEND_NONE) begin
          ctl.loadPend = 1'b1; ctl.nextPend = PEND_TO_S;
        end
      end

      TR_SM_AD: begin
        if (ownGetM) begin
          ctl.loadTrans = 1'b1; ctl.nextTrans = TR_IM_D;
          ctl.loadStable = 1'b1; ctl.nextStable = ST_I;
          ctl.loadPend = 1'b1; ctl.nextPend = PEND_NONE;
        end else if (otherGetM) begin
          ctl.loadTrans = 1'b1; ctl.nextTrans = TR_IM_AD;
          ctl.loadStable = 1'b1; ctl.nextStable = ST_I;
        end
      end

      TR_MI_A: begin
        if (ownPutM) begin
          ctl.loadTrans = 1'b1; ctl.nextTrans = TR_NONE;
          ctl.loadStable = 1'b1; ctl.nextStable = ST_I;
          ctl.send = 1'b1; ctl.sendMem = 1'b1;
          ctl.done = 1'b1;
        end else if (otherGetM) begin
          ctl.loadTrans = 1'b1; ctl.nextTrans = TR_II_A;
          ctl.loadStable = 1'b1; ctl.nextStable = ST_I;
          ctl.send = 1'b1; ctl.sendMem = 1'b0;
        end else if (otherGetS) begin
          ctl.loadTrans = 1'b1; ctl.nextTrans = TR_II_A;
          ctl.loadStable = 1'b1; ctl.nextStable = ST_I;
          ctl.send = 1'b1; ctl.sendMem = 1'b1;
        end
      end

      TR_II_A: begin
        if (ownPutM) begin
          ctl.loadTrans = 1'b1; ctl.nextTrans = TR_NONE;
          ctl.done = 1'b1;
        end
      end

      default: ;
    endcase
  end

endmodule

// File: rtl/snoop_line_ctrl.sv
module snoop_line_ctrl
  import snoop_line_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             coreValid,
  input  logic [OP_W-1:0]  coreOp,
  output logic             coreReady,
  output logic             coreDone,
  input  logic             snoopValid,
  input  logic [BUS_W-1:0] snoopType,
  input  logic             snoopOwn,
  input  logic             sharedIn,
  output logic             sharedOut,
  input  logic             dataRespValid,
  output logic             busReqValid,
  output logic [BUS_W-1:0] busReqType,
  output logic             dataSendValid,
  output logic             dataSendMem
);

  strobes_t ctl;
  stable_e  stableQ;
  trans_e   transQ;
  logic     sharedQ;
  pend_e    pendQ;

  snoop_line_fsm fsm_i (
    .stableQ       (stableQ),
    .transQ        (transQ),
    .sharedQ       (sharedQ),
    .pendQ         (pendQ),
    .coreValid     (coreValid),
    .coreOp        (coreOp),
    .coreReady     (coreReady),
    .snoopValid    (snoopValid),
    .snoopType     (snoopType),
    .snoopOwn      (snoopOwn),
    .dataRespValid (dataRespValid),
    .ctl           (ctl)
  );

  snoop_line_dp dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .sharedIn      (sharedIn),
    .snoopValid    (snoopValid),
    .snoopOwn      (snoopOwn),
    .snoopType     (snoopType),
    .stableQ       (stableQ),
    .transQ        (transQ),
    .sharedQ       (sharedQ),
    .pendQ         (pendQ),
    .busReqValid   (busReqValid),
    .busReqType    (busReqType),
    .coreReady     (coreReady),
    .sharedOut     (sharedOut),
    .coreDone      (coreDone),
    .dataSendValid (dataSendValid),
    .dataSendMem   (dataSendMem)
  );

endmodule

// File: rtl/snoop_line_chk.sv
module snoop_line_chk
  import snoop_line_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             coreValid,
  input logic             coreReady,
  input logic             coreDone,
  input logic             snoopValid,
  input logic [BUS_W-1:0] snoopType,
  input logic             snoopOwn,
  input logic             sharedOut,
  input logic             dataRespValid,
  input logic             busReqValid,
  input logic [BUS_W-1:0] busReqType,
  input logic             dataSendValid
);

  // R9: an outstanding bus request always blocks the core port.
  assert_req_blocks_core_R9: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid |-> !coreReady);

  // R10: shared line answers only a foreign GetS.
  assert_shared_only_foreign_gets_R10: assert property (@(posedge clk) disable iff (!rstN)
    sharedOut |-> (snoopValid && !snoopOwn && snoopType == BUS_GETS));

  // R2: a new bus request follows an accepted core request.
  assert_req_from_core_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReqValid) |-> $past(coreValid && coreReady));

  // R3: request type holds while the request is outstanding.
  assert_req_type_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && $past(busReqValid)) |-> $stable(busReqType));

  // R12: completion pulses have a cause in the previous cycle.
  assert_done_cause_R12: assert property (@(posedge clk) disable iff (!rstN)
    coreDone |-> $past((coreValid && coreReady) || (snoopValid && snoopOwn) || dataRespValid));

  // R12: data sends follow a snoop or a data response.
  assert_send_cause_R12: assert property (@(posedge clk) disable iff (!rstN)
    dataSendValid |-> $past(snoopValid || dataRespValid));

endmodule

bind snoop_line_ctrl snoop_line_chk chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .coreValid     (coreValid),
  .coreReady     (coreReady),
  .coreDone      (coreDone),
  .snoopValid    (snoopValid),
  .snoopType     (snoopType),
  .snoopOwn      (snoopOwn),
  .sharedOut     (sharedOut),
  .dataRespValid (dataRespValid),
  .busReqValid   (busReqValid),
  .busReqType    (busReqType),
  .dataSendValid (dataSendValid)
);

// File: tb/snoop_line_ctrl_tb.sv
module snoop_line_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       coreValid = 1'b0;
  logic [1:0] coreOp = 2'd0;
  logic       coreReady, coreDone;
  logic       snoopValid = 1'b0;
  logic [1:0] snoopType = 2'd0;
  logic       snoopOwn = 1'b0;
  logic       sharedIn = 1'b0;
  logic       sharedOut;
  logic       dataRespValid = 1'b0;
  logic       busReqValid;
  logic [1:0] busReqType;
  logic       dataSendValid, dataSendMem;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  localparam int WATCHDOG = 5000;

  always #5 clk = ~clk;

  snoop_line_ctrl dut_i (
    .clk(clk), .rstN(rstN),
    .coreValid(coreValid), .coreOp(coreOp), .coreReady(coreReady), .coreDone(coreDone),
    .snoopValid(snoopValid), .snoopType(snoopType), .snoopOwn(snoopOwn),
    .sharedIn(sharedIn), .sharedOut(sharedOut), .dataRespValid(dataRespValid),
    .busReqValid(busReqValid), .busReqType(busReqType),
    .dataSendValid(dataSendValid), .dataSendMem(dataSendMem)
  );

  // Row layout: cv op sv st so sh dr | req typ shr rdy | done send mem
  // op: 0 load 1 store 2 replace; bus type: 0 GetS 1 GetM 2 PutM.
  localparam int NROWS = 62;
  localparam logic [16:0] VEC [NROWS] = '{
    17'b1_00_0_00_0_0_0_0_00_0_1_0_0_0, // 0  load miss R2
    17'b0_00_0_00_0_0_0_1_00_0_0_0_0_0, // 1  GetS waiting R2 R9
    17'b0_00_1_00_1_0_0_1_00_0_0_0_0_0, // 2  own GetS, not shared
    17'b0_00_0_00_0_0_0_0_00_0_0_0_0_0, // 3  waiting for data
    17'b0_00_0_00_0_0_1_0_00_0_0_1_0_0, // 4  data -> E R2
    17'b0_00_1_00_0_0_0_0_00_1_0_0_0_0, // 5  foreign GetS on E: silent to S R5 R10
    17'b1_01_0_00_0_0_0_0_00_0_1_0_0_0, // 6  store on S R4
    17'b0_00_1_01_0_0_0_1_01_0_0_0_0_0, // 7  foreign GetM first R4
    17'b0_00_1_01_1_0_0_1_01_0_0_0_0_0, // 8  own GetM
    17'b0_00_0_00_0_0_1_0_00_0_0_1_0_0, // 9  data -> M R4
    17'b0_00_1_00_0_0_0_0_00_1_0_0_1_1, // 10 foreign GetS on M R6
    17'b1_01_0_00_0_0_0_0_00_0_1_0_0_0, // 11 store on S
    17'b0_00_1_01_1_0_0_1_01_0_0_0_0_0, // 12 own GetM wins R4
    17'b0_00_0_00_0_0_1_0_00_0_0_1_0_0, // 13 data -> M
    17'b1_00_0_00_0_0_0_0_00_0_1_1_0_0, // 14 load hit
    17'b1_10_0_00_0_0_0_0_00_0_1_0_0_0, // 15 replace M R8
    17'b0_00_1_01_0_0_0_1_10_0_0_0_1_0, // 16 foreign GetM beats PutM R8
    17'b0_00_1_10_1_0_0_1_10_0_0_1_0_0, // 17 own PutM, no data R8
    17'b0_00_0_00_0_0_0_0_00_0_1_0_0_0, // 18 idle
    17'b1_00_0_00_0_0_0_0_00_0_1_0_0_0, // 19 load miss
    17'b0_00_1_00_1_1_0_1_00_0_0_0_0_0, // 20 own GetS, shared R2
    17'b0_00_0_00_0_0_1_0_00_0_0_1_0_0, // 21 data -> S R2
    17'b0_00_1_00_0_0_0_0_00_1_0_0_0_0, // 22 foreign GetS on S R10
    17'b1_10_0_00_0_0_0_0_00_0_1_1_0_0, // 23 replace S silent
    17'b0_00_1_00_0_0_0_0_00_0_0_0_0_0, // 24 foreign GetS on I R10
    17'b1_01_0_00_0_0_0_0_00_0_1_0_0_0, // 25 store miss R3
    17'b0_00_0_00_0_0_0_1_01_0_0_0_0_0, // 26 GetM waiting R3
    17'b0_00_1_01_1_0_0_1_01_0_0_0_0_0, // 27 own GetM
    17'b0_00_1_01_0_0_0_0_00_0_0_0_0_0, // 28 foreign GetM while awaiting data R11
    17'b0_00_0_00_0_0_1_0_00_0_0_1_1_0, // 29 data: done and forward R11
    17'b1_00_0_00_0_0_0_0_00_0_1_0_0_0, // 30 load miss
    17'b0_00_1_00_1_0_0_1_00_0_0_0_0_0, // 31 own GetS
    17'b0_00_0_00_0_0_1_0_00_0_0_1_0_0, // 32 data -> E
    17'b1_01_0_00_0_0_0_0_00_0_1_1_0_0, // 33 store on E silent R5
    17'b0_00_0_00_0_0_0_0_00_0_1_0_0_0, // 34 no request follows R5
    17'b0_00_1_01_0_0_0_0_00_0_0_0_1_0, // 35 foreign GetM on M R6
    17'b1_01_0_00_0_0_0_0_00_0_1_0_0_0, // 36 store miss R3
    17'b0_00_1_01_1_0_0_1_01_0_0_0_0_0, // 37 own GetM
    17'b0_00_1_00_0_0_0_0_00_0_0_0_0_0, // 38 foreign GetS while awaiting data R11
    17'b0_00_0_00_0_0_1_0_00_0_0_1_1_1, // 39 data: done, forward to memory R11
    17'b0_00_1_00_0_0_0_0_00_1_0_0_0_0, // 40 line now S R11
    17'b1_01_0_00_0_0_0_0_00_0_1_0_0_0, // 41 store on S
    17'b0_00_1_01_1_0_0_1_01_0_0_0_0_0, // 42 own GetM
    17'b0_00_0_00_0_0_1_0_00_0_0_1_0_0, // 43 data -> M
    17'b1_10_0_00_0_0_0_0_00_0_1_0_0_0, // 44 replace M R7
    17'b0_00_0_00_0_0_0_1_10_0_0_0_0_0, // 45 PutM waiting R7
    17'b0_00_1_10_1_0_0_1_10_0_0_1_1_1, // 46 own PutM: data to memory R7
    17'b0_00_0_00_0_0_0_0_00_0_1_0_0_0, // 47 idle
    17'b1_00_0_00_0_0_0_0_00_0_1_0_0_0, // 48 load miss
    17'b0_00_1_00_1_0_0_1_00_0_0_0_0_0, // 49 own GetS
    17'b0_00_0_00_0_0_1_0_00_0_0_1_0_0, // 50 data -> E
    17'b1_01_1_00_0_0_0_0_00_1_0_0_0_0, // 51 store meets foreign GetS R9
    17'b1_01_0_00_0_0_0_0_00_0_1_0_0_0, // 52 held store now on S R9
    17'b0_00_0_00_0_0_0_1_01_0_0_0_0_0, // 53 GetM, not silent R9
    17'b0_00_1_01_1_0_0_1_01_0_0_0_0_0, // 54 own GetM
    17'b0_00_0_00_0_0_1_0_00_0_0_1_0_0, // 55 data -> M
    17'b0_00_1_01_0_0_0_0_00_0_0_0_1_0, // 56 foreign GetM on M R6
    17'b1_00_0_00_0_0_0_0_00_0_1_0_0_0, // 57 load miss
    17'b0_00_1_00_1_0_0_1_00_0_0_0_0_0, // 58 own GetS
    17'b0_00_0_00_0_0_1_0_00_0_0_1_0_0, // 59 data -> E
    17'b1_10_0_00_0_0_0_0_00_0_1_1_0_0, // 60 replace E silent R5
    17'b0_00_1_00_0_0_0_0_00_0_0_0_0_0  // 61 line is I: no shared answer R5
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    while (cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL R1 watchdog: cycles %0d expected below %0d", cycles, WATCHDOG);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #4;
    // R1: reset state
    check(coreReady == 1'b1, "R1", "coreReady after reset", coreReady, 1);
    check(busReqValid == 1'b0, "R1", "busReqValid after reset", busReqValid, 0);
    check(sharedOut == 1'b0, "R1", "sharedOut after reset", sharedOut, 0);
    @(posedge clk); #1;
    check(coreDone == 1'b0, "R1", "coreDone after reset", coreDone, 0);
    check(dataSendValid == 1'b0, "R1", "dataSendValid after reset", dataSendValid, 0);

    for (int i = 0; i < NROWS; i++) begin
      logic [16:0] v;
      v = VEC[i];
      @(negedge clk);
      coreValid     = v[16];
      coreOp        = v[15:14];
      snoopValid    = v[13];
      snoopType     = v[12:11];
      snoopOwn      = v[10];
      sharedIn      = v[9];
      dataRespValid = v[8];
      #4;
      check(busReqValid == v[7], "R2", $sformatf("row %0d busReqValid", i), busReqValid, v[7]);
      if (v[7])
        check(busReqType == v[6:5], "R3", $sformatf("row %0d busReqType", i), busReqType, v[6:5]);
      check(sharedOut == v[4], "R10", $sformatf("row %0d sharedOut", i), sharedOut, v[4]);
      check(coreReady == v[3], "R9", $sformatf("row %0d coreReady", i), coreReady, v[3]);
      @(posedge clk); #1;
      check(coreDone == v[2], "R12", $sformatf("row %0d coreDone", i), coreDone, v[2]);
      check(dataSendValid == v[1], "R6", $sformatf("row %0d dataSendValid", i), dataSendValid, v[1]);
      if (v[1])
        check(dataSendMem == v[0], "R6", $sformatf("row %0d dataSendMem", i), dataSendMem, v[0]);
    end

    @(negedge clk);
    coreValid = 1'b0; snoopValid = 1'b0; dataRespValid = 1'b0; sharedIn = 1'b0;
    // R12: pulses last a single cycle
    @(posedge clk); #1;
    check(coreDone == 1'b0, "R12", "coreDone after idle", coreDone, 0);
    check(dataSendValid == 1'b0, "R12", "dataSendValid after idle", dataSendValid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule